// File: doc/BRIEF.md
# Serial Configuration Register Port

A write-only, three-wire configuration port for the control logic of a sampling converter. An external controller shifts bits in on a data line, using its own configuration clock. It then pulses a latch strobe. The block keeps an 8-bit shift register. On the strobe it splits the most recent eight bits into a 3-bit address and a 5-bit payload, and writes the payload into the register the address names. The registers drive the conversion-mode, pre-trigger-mode, threshold-level, offset-calibration-enable and stored-offset outputs.

The configuration clock, data line and latch strobe are asynchronous to the system clock. All three pass through two-flop synchronisers. Edge detectors in the system clock domain then find the shift and commit events. A master reset clears every register asynchronously, at any time, without waiting for a clock edge.

Top module: `cfg_serial_port`

## Requirements
- R1: Each rising edge of `cfg_clk_i` shifts the level of `cfg_dat_i` into the shift register. The first bit shifted ends up as byte bit 7, so bytes are sent most-significant bit first.
- R2: Any number of bits may be shifted before a latch. Only the last eight bits shifted before the latch are used, and earlier bits have no effect.
- R3: Register outputs change only on a rising edge of `cfg_lat_i`. They hold their new value no later than the third rising edge of `clk_i` after that input edge. Configuration clock edges without a latch leave every output unchanged.
- R4: Byte bits [7:5] are the address and bits [4:0] are the payload. Address 0 loads payload[2:0] into `conv_mode_o`, and payload bits [4:3] are ignored.
- R5: Address 1 loads payload[1:0] into `trig_mode_o`.
- R6: Address 2 loads the full 5-bit payload into `thr_level_o`.
- R7: Address 3 loads payload[0] into `cal_en_o`.
- R8: Address 4 loads the payload into `cal_ofs_o[4:0]`, and address 5 loads it into `cal_ofs_o[9:5]`. The other half is unchanged.
- R9: A write to address 6 or 7 changes no output.
- R10: While `rst_ni` is low, the outputs take these values, independent of `clk_i`: `conv_mode_o`=3, `trig_mode_o`=0, `thr_level_o`=16, `cal_en_o`=0, `cal_ofs_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| cfg_clk_i | input | 1 | Configuration shift clock, asynchronous |
| cfg_dat_i | input | 1 | Configuration serial data |
| cfg_lat_i | input | 1 | Latch strobe; its rising edge commits the byte |
| conv_mode_o | output | 3 | Conversion mode |
| trig_mode_o | output | 2 | Pre-trigger mode |
| thr_level_o | output | 5 | Threshold level code |
| cal_en_o | output | 1 | Offset-calibration enable |
| cal_ofs_o | output | 10 | Stored offset-calibration value |

## Verification
The assertions assume the following about the inputs:
- Each level on the three configuration inputs lasts for several system clock cycles.
- `cfg_dat_i` is stable around every `cfg_clk_i` rising edge.
- `cfg_clk_i` and `cfg_lat_i` never rise together.

Under these conditions a synchronised latch pulse can be tied to the byte that was in the shift register one cycle earlier. The stimulus holds every configuration phase for three or four system clocks and toggles one wire at a time. It also keeps the configuration clock low and the latch low whenever reset is released.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int PAY_W  = BYTE_W - ADDR_W;
  localparam int OFS_W  = 2 * PAY_W;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CONV   = 3'd0,
    ADDR_TRIG   = 3'd1,
    ADDR_THR    = 3'd2,
    ADDR_CAL    = 3'd3,
    ADDR_OFS_LO = 3'd4,
    ADDR_OFS_HI = 3'd5
  } cfg_addr_e;

  localparam logic [2:0]       CONV_RST = 3'd3;
  localparam logic [1:0]       TRIG_RST = 2'd0;
  localparam logic [PAY_W-1:0] THR_RST  = 5'd16;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o
);
  // keeps shifting past BYTE_W bits: only the newest byte survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      byte_o <= '0;
    else if (shift_i) byte_o <= {byte_o[BYTE_W-2:0], bit_i};
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [2:0]        conv_mode_o,
  output logic [1:0]        trig_mode_o,
  output logic [PAY_W-1:0]  thr_level_o,
  output logic              cal_en_o,
  output logic [OFS_W-1:0]  cal_ofs_o
);
  logic [ADDR_W-1:0] addr;
  logic [PAY_W-1:0]  pay;

  assign addr = byte_i[BYTE_W-1:PAY_W];
  assign pay  = byte_i[PAY_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_mode_o <= CONV_RST;
      trig_mode_o <= TRIG_RST;
      thr_level_o <= THR_RST;
      cal_en_o    <= 1'b0;
      cal_ofs_o   <= '0;
    end else if (we_i) begin
      case (cfg_addr_e'(addr))
        ADDR_CONV:   conv_mode_o <= pay[2:0];
        ADDR_TRIG:   trig_mode_o <= pay[1:0];
        ADDR_THR:    thr_level_o <= pay;
        ADDR_CAL:    cal_en_o    <= pay[0];
        ADDR_OFS_LO: cal_ofs_o[PAY_W-1:0]     <= pay;
        ADDR_OFS_HI: cal_ofs_o[OFS_W-1:PAY_W] <= pay;
        default: ;  // unimplemented addresses dropped
      endcase
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_clk_i,
  input  logic             cfg_dat_i,
  input  logic             cfg_lat_i,
  output logic [2:0]       conv_mode_o,
  output logic [1:0]       trig_mode_o,
  output logic [PAY_W-1:0] thr_level_o,
  output logic             cal_en_o,
  output logic [OFS_W-1:0] cal_ofs_o
);
  logic              clk_s, dat_s, lat_s;
  logic              clk_d, lat_d;
  logic              shift_en, lat_rise;
  logic [BYTE_W-1:0] shreg;

  cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cfg_lat_i, cfg_clk_i, cfg_dat_i}),
    .q_o   ({lat_s, clk_s, dat_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_d <= 1'b0;
      lat_d <= 1'b0;
    end else begin
      clk_d <= clk_s;
      lat_d <= lat_s;
    end
  end

  assign shift_en = clk_s & ~clk_d;
  assign lat_rise = lat_s & ~lat_d;

  cfg_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .bit_i  (dat_s),
    .byte_o (shreg)
  );

  cfg_regfile u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (lat_rise),
    .byte_i     (shreg),
    .conv_mode_o(conv_mode_o),
    .trig_mode_o(trig_mode_o),
    .thr_level_o(thr_level_o),
    .cal_en_o   (cal_en_o),
    .cal_ofs_o  (cal_ofs_o)
  );
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       commit_i,
  input logic [7:0] byte_i,
  input logic [2:0] conv_mode_i,
  input logic [1:0] trig_mode_i,
  input logic [4:0] thr_level_i,
  input logic       cal_en_i,
  input logic [9:0] cal_ofs_i
);
  logic [20:0] regs;
  assign regs = {conv_mode_i, trig_mode_i, thr_level_i, cal_en_i, cal_ofs_i};

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(regs));

  assert_conv_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && byte_i[7:5] == 3'd0 |=> conv_mode_i == $past(byte_i[2:0]));

  assert_trig_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && byte_i[7:5] == 3'd1 |=> trig_mode_i == $past(byte_i[1:0]));

  assert_thr_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && byte_i[7:5] == 3'd2 |=> thr_level_i == $past(byte_i[4:0]));

  assert_cal_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && byte_i[7:5] == 3'd3 |=> cal_en_i == $past(byte_i[0]));

  assert_ofs_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && byte_i[7:5] == 3'd4 |=>
      cal_ofs_i[4:0] == $past(byte_i[4:0]) && $stable(cal_ofs_i[9:5]));

  assert_ofs_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && byte_i[7:5] == 3'd5 |=>
      cal_ofs_i[9:5] == $past(byte_i[4:0]) && $stable(cal_ofs_i[4:0]));

  assert_unimpl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && byte_i[7:6] == 2'b11 |=> $stable(regs));
endmodule

bind cfg_serial_port cfg_serial_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .commit_i   (lat_rise),
  .byte_i     (shreg),
  .conv_mode_i(conv_mode_o),
  .trig_mode_i(trig_mode_o),
  .thr_level_i(thr_level_o),
  .cal_en_i   (cal_en_o),
  .cal_ofs_i  (cal_ofs_o)
);

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       c_clk = 1'b0, c_dat = 1'b0, c_lat = 1'b0;
  logic [2:0] conv;
  logic [1:0] trig;
  logic [4:0] thr;
  logic       cal;
  logic [9:0] ofs;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // model registers
  logic [2:0] m_conv;
  logic [1:0] m_trig;
  logic [4:0] m_thr;
  logic       m_cal;
  logic [9:0] m_ofs;

  always #10 clk = ~clk;  // 50 MHz

  cfg_serial_port dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_clk_i(c_clk), .cfg_dat_i(c_dat), .cfg_lat_i(c_lat),
    .conv_mode_o(conv), .trig_mode_o(trig), .thr_level_o(thr),
    .cal_en_o(cal), .cal_ofs_o(ofs)
  );

  function automatic logic [20:0] model_word();
    return {m_conv, m_trig, m_thr, m_cal, m_ofs};
  endfunction

  task automatic model_reset();
    m_conv = 3'd3; m_trig = 2'd0; m_thr = 5'd16; m_cal = 1'b0; m_ofs = '0;
  endtask

  task automatic check(input string tag);
    logic [20:0] got, exp;
    got = {conv, trig, thr, cal, ofs};
    exp = model_word();
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R1: one bit per rising configuration clock edge
  task automatic send_bit(input logic b);
    c_dat = b;
    wait_clk(3);
    c_clk = 1'b1;
    wait_clk(3);
    c_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_latch();
    wait_clk(2);
    c_lat = 1'b1;
    wait_clk(4);  // commit visible by the third edge
    c_lat = 1'b0;
    wait_clk(2);
  endtask

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4, 3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    model_reset();
    wait_clk(3);
    check("R10 reset");
    rst_n = 1'b1;
    wait_clk(3);
    check("R10 after release");

    for (int a = 0; a < 8; a++) begin
      for (int p = 0; p < 32; p++) begin
        logic [7:0] v;
        int k;
        v = {a[2:0], p[4:0]};
        k = (a + p) % 5;
        // R2: leading junk bits must be pushed out
        for (int j = 0; j < k; j++) send_bit(~v[j % 8]);
        send_byte(v);
        wait_clk(4);
        check("R3 no commit before latch");
        pulse_latch();
        case (a)
          0: m_conv = v[2:0];
          1: m_trig = v[1:0];
          2: m_thr = v[4:0];
          3: m_cal = v[0];
          4: m_ofs[4:0] = v[4:0];
          5: m_ofs[9:5] = v[4:0];
          default: ;
        endcase
        check(k != 0 ? {tag_of(a[2:0]), " R2 prefix"} : tag_of(a[2:0]));
      end
    end

    // R2: an over-long stream (16 bits) keeps only the tail byte
    send_byte(8'h1F);
    send_byte(8'h45);
    pulse_latch();
    m_thr = 5'h05;
    check("R2 long stream");

    // R10: mid-run asynchronous reset, sampled before any clock edge
    @(posedge clk);
    #3 rst_n = 1'b0;
    #2;
    model_reset();
    check("R10 async reset");
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(3);
    check("R10 defaults held");

    done = 1;
    summary();
  end

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end
endmodule